// File: doc/BRIEF.md
# Dual-Capture Pulse Width Timer

This block measures pulse widths on one external input. A free-running up-counter advances on each count-enable tick. A filtered copy of the input pin is watched for edges. A programmable mode chooses which edge is the "valid" edge. The valid edge copies the counter into capture register A and raises a one-cycle interrupt. The opposite edge copies the counter into capture register B. Software subtracts one capture from the other to get the width of the high or low phase in ticks.

The pin is sampled only on ticks. A new level is accepted only after the same value has been seen on consecutive ticks, so glitches shorter than the filter length are dropped. When both edges are made valid, register A captures on every edge and register B is never written. A counter wrap sets a sticky overflow flag, which stays set until a clear strobe removes it.

Top module: `pulse_width_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `cap_a`, `cap_b`, `irq` and `ovf` become 0 and the internal counter becomes 0.
- R2: The counter advances by one on every clock edge where `tick` is high. It is never cleared or reloaded by a capture. Two captures therefore differ by the number of ticks between them.
- R3: With `edge_mode` = 2'b01 a rising edge is valid; with 2'b00 a falling edge is valid. On a valid edge, `cap_a` takes the counter value of the tick in which the filtered level changes. `irq` is high for exactly the one clock cycle that follows that edge.
- R4: In modes 2'b00 and 2'b01, the edge opposite to the valid one loads `cap_b` with the counter value of that tick. It leaves `cap_a` unchanged and raises no `irq`.
- R5: With `edge_mode` = 2'b11 every filtered edge loads `cap_a` and pulses `irq`, and `cap_b` never changes.
- R6: With `edge_mode` = 2'b10 no edge loads either capture register and `irq` stays low.
- R7: A new pin level is accepted only on a tick where the pin shows the same level it showed on the previous tick (FILTER_LEN = 2). A level held for a single tick causes no capture.
- R8: On cycles with `tick` low, the counter, the filter and both capture registers hold, and `irq` stays low.
- R9: A tick at counter value all-ones wraps the counter to 0 and sets `ovf`. `ovf` stays set until `ovf_clr` is high at a clock edge. A wrap in the same cycle as `ovf_clr` leaves `ovf` set.
- R10: Reset loads the filter with the current pin level. A pin that is already high when reset ends therefore produces no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable tick; counter and filter advance only when high |
| pin_in | input | 1 | Raw measured input, synchronous to `clk` |
| edge_mode | input | 2 | Valid-edge select: 00 falling, 01 rising, 10 none, 11 both |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_a | output | CNT_W | Counter value latched on the valid edge |
| cap_b | output | CNT_W | Counter value latched on the opposite edge |
| irq | output | 1 | One-cycle pulse after each `cap_a` load |
| ovf | output | 1 | Sticky counter-wrap flag |

## Verification
A pin change first presented on tick k is accepted on tick k+1. `cap_a` or `cap_b` holds the value k+1, and any `irq` pulse appears, right after that clock edge. `ovf` changes after the edge of the wrapping tick or the clearing cycle. The bench drives inputs on the falling clock edge. It samples one nanosecond after each rising edge and counts `irq` pulses over each stimulus window. It compares captures against its own count of ticks since reset, so every expected value lines up with the edge that produced it.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

   typedef enum logic [1:0] {
      MODE_FALL = 2'b00,
      MODE_RISE = 2'b01,
      MODE_OFF  = 2'b10,
      MODE_BOTH = 2'b11
   } edge_mode_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;

   typedef struct packed {
      logic to_a;
      logic to_b;
   } load_t;

   function automatic load_t route_edge(edge_mode_e mode, edge_ev_t ev);
      load_t r;
      r = '0;
      unique case (mode)
         MODE_RISE: begin
            r.to_a = ev.rise;
            r.to_b = ev.fall;
         end
         MODE_FALL: begin
            r.to_a = ev.fall;
            r.to_b = ev.rise;
         end
         MODE_BOTH: begin
            r.to_a = ev.rise | ev.fall;
            r.to_b = 1'b0;
         end
         MODE_OFF: begin
            r.to_a = 1'b0;
            r.to_b = 1'b0;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pwt_filter.sv
module pwt_filter #(
   parameter int unsigned STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic               pin,
   output logic               level,
   output pwt_pkg::edge_ev_t  ev
);
   localparam int unsigned HIST = (STAGES > 1) ? STAGES - 1 : 1;

   logic agree;

   generate
      if (STAGES == 1) begin : g_direct
         assign agree = 1'b1;
      end else begin : g_hist
         logic [HIST-1:0] hist;
         always_ff @(posedge clk) begin
            if (rst)
               hist <= {HIST{pin}};
            else if (tick)
               hist <= (hist << 1) | HIST'(pin);
         end
         assign agree = (hist == {HIST{pin}});
      end
   endgenerate

   logic accept;
   assign accept = tick && agree && (pin != level);

   always_ff @(posedge clk) begin
      if (rst)
         level <= pin;
      else if (accept)
         level <= pin;
   end

   assign ev.rise = accept &  pin;
   assign ev.fall = accept & ~pin;

endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic wrap;
   assign wrap = tick && (count == TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (tick)
            count <= count + CNT_W'(1);
         if (wrap)
            ovf <= 1'b1;
         else if (ovf_clr)
            ovf <= 1'b0;
      end
   end

endmodule

// File: rtl/pwt_capture.sv
module pwt_capture #(
   parameter int unsigned CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  pwt_pkg::edge_mode_e mode,
   input  pwt_pkg::edge_ev_t   ev,
   input  logic [CNT_W-1:0]    count,
   output logic [CNT_W-1:0]    cap_a,
   output logic [CNT_W-1:0]    cap_b,
   output logic                irq
);
   pwt_pkg::load_t ld;
   assign ld = pwt_pkg::route_edge(mode, ev);

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_a <= '0;
         cap_b <= '0;
         irq   <= 1'b0;
      end else begin
         if (ld.to_a)
            cap_a <= count;
         if (ld.to_b)
            cap_b <= count;
         irq <= ld.to_a;
      end
   end

endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned FILTER_LEN = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             pin_in,
   input  logic [1:0]       edge_mode,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cap_a,
   output logic [CNT_W-1:0] cap_b,
   output logic             irq,
   output logic             ovf
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pulse_width_timer: CNT_W must lie in 2..32");
      end
      if (FILTER_LEN < 1 || FILTER_LEN > 8) begin : g_bad_filter
         $error("pulse_width_timer: FILTER_LEN must lie in 1..8");
      end
   endgenerate

   pwt_pkg::edge_mode_e mode_e;
   pwt_pkg::edge_ev_t   ev;
   logic [CNT_W-1:0]    count_q;
   logic                level_q;

   assign mode_e = pwt_pkg::edge_mode_e'(edge_mode);

   pwt_filter #(.STAGES(FILTER_LEN)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .pin   (pin_in),
      .level (level_q),
      .ev    (ev)
   );

   pwt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .ovf_clr (ovf_clr),
      .count   (count_q),
      .ovf     (ovf)
   );

   pwt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk   (clk),
      .rst   (rst),
      .mode  (mode_e),
      .ev    (ev),
      .count (count_q),
      .cap_a (cap_a),
      .cap_b (cap_b),
      .irq   (irq)
   );

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             ovf_clr,
   input logic [1:0]       edge_mode,
   input logic [CNT_W-1:0] cap_a,
   input logic [CNT_W-1:0] cap_b,
   input logic             irq,
   input logic             ovf,
   input logic [CNT_W-1:0] count,
   input logic             level
);
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= !rst;

   // R2
   a_r2_count_step: assert property (@(posedge clk) disable iff (rst || !armed)
      tick |=> count == $past(count) + CNT_W'(1));

   // R3
   a_r3_irq_single: assert property (@(posedge clk) disable iff (rst || !armed)
      irq |=> !irq);

   a_r3_irq_holds_count: assert property (@(posedge clk) disable iff (rst || !armed)
      irq |-> cap_a == $past(count));

   // R4
   a_r4_b_needs_tick: assert property (@(posedge clk) disable iff (rst || !armed)
      !$stable(cap_b) |-> $past(tick) && !$past(edge_mode[1]));

   // R5
   a_r5_both_keeps_b: assert property (@(posedge clk) disable iff (rst || !armed)
      edge_mode == 2'b11 |=> $stable(cap_b));

   // R6
   a_r6_off_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
      edge_mode == 2'b10 |=> !irq && $stable(cap_a) && $stable(cap_b));

   // R8
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst || !armed)
      !tick |=> $stable(count) && $stable(cap_a) && $stable(cap_b) && $stable(level) && !irq);

   // R9
   a_r9_wrap_sets: assert property (@(posedge clk) disable iff (rst || !armed)
      tick && count == '1 |=> ovf && count == '0);

   a_r9_sticky: assert property (@(posedge clk) disable iff (rst || !armed)
      ovf && !ovf_clr |=> ovf);

   a_r9_clear: assert property (@(posedge clk) disable iff (rst || !armed)
      ovf_clr && !tick |=> !ovf);

endmodule

bind pulse_width_timer pwt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .ovf_clr   (ovf_clr),
   .edge_mode (edge_mode),
   .cap_a     (cap_a),
   .cap_b     (cap_b),
   .irq       (irq),
   .ovf       (ovf),
   .count     (count_q),
   .level     (level_q)
);

// File: tb/sim_pulse_width_timer.sv
`timescale 1ns/1ps
module sim_pulse_width_timer;
   localparam int W = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst = 1'b1, tick = 1'b0, pin = 1'b0, ovf_clr = 1'b0;
   logic [1:0]   mode = 2'b01;
   logic [W-1:0] cap_a, cap_b;
   logic         irq, ovf;

   pulse_width_timer #(.CNT_W(W), .FILTER_LEN(2)) u0 (
      .clk(clk), .rst(rst), .tick(tick), .pin_in(pin), .edge_mode(mode),
      .ovf_clr(ovf_clr), .cap_a(cap_a), .cap_b(cap_b), .irq(irq), .ovf(ovf));

   int checks = 0, fails = 0, irq_seen = 0;
   logic [W-1:0] n = '0;            // ticks since reset, wrapping
   logic [W-1:0] exp_a = '0, exp_b = '0, s;
   bit finished = 1'b0;

   // [8:7] mode, [6] level, [5:2] ticks held, [1:0] expected load: 0 none, 1 A, 2 B
   localparam logic [8:0] VEC [12] = '{
      {2'b01, 1'b1, 4'd3, 2'd1},
      {2'b01, 1'b0, 4'd3, 2'd2},
      {2'b00, 1'b1, 4'd4, 2'd2},
      {2'b00, 1'b0, 4'd2, 2'd1},
      {2'b11, 1'b1, 4'd3, 2'd1},
      {2'b11, 1'b0, 4'd3, 2'd1},
      {2'b10, 1'b1, 4'd3, 2'd0},
      {2'b10, 1'b0, 4'd2, 2'd0},
      {2'b01, 1'b0, 4'd2, 2'd0},
      {2'b01, 1'b1, 4'd2, 2'd1},
      {2'b00, 1'b1, 4'd3, 2'd0},
      {2'b00, 1'b0, 4'd5, 2'd1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic p, input logic t, input logic [1:0] m);
      @(negedge clk);
      pin = p; tick = t; mode = m;
      @(posedge clk);
      #1;
      if (irq) irq_seen++;
      if (t) n++;
   endtask

   task automatic do_reset(input logic p, input logic [1:0] m);
      @(negedge clk);
      rst = 1'b1; pin = p; tick = 1'b0; mode = m; ovf_clr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      n = '0; exp_a = '0; exp_b = '0;
      #1;
   endtask

   function automatic string tag_of(input logic [1:0] m, input logic [1:0] k);
      if (m == 2'b11) return "R5";
      if (m == 2'b10) return "R6";
      if (k == 2'd2)  return "R4";
      return "R2 R3";
   endfunction

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual still running, expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0, 2'b01);
      chk("R1 cap_a", cap_a, 0);
      chk("R1 cap_b", cap_b, 0);
      chk("R1 irq", irq, 0);
      chk("R1 ovf", ovf, 0);

      for (int i = 0; i < 12; i++) begin
         logic [8:0] v;
         v = VEC[i];
         s = n;
         irq_seen = 0;
         for (int h = 0; h < int'(v[5:2]); h++) step(v[6], 1'b1, v[8:7]);
         if (v[1:0] == 2'd1) exp_a = s + 1'b1;
         if (v[1:0] == 2'd2) exp_b = s + 1'b1;
         chk({tag_of(v[8:7], v[1:0]), " cap_a"}, cap_a, exp_a);
         chk({tag_of(v[8:7], v[1:0]), " cap_b"}, cap_b, exp_b);
         chk({tag_of(v[8:7], v[1:0]), " irq pulses"}, irq_seen, (v[1:0] == 2'd1) ? 1 : 0);
      end

      // R7: one-tick high glitch is rejected
      irq_seen = 0;
      step(1'b1, 1'b1, 2'b01);
      step(1'b0, 1'b1, 2'b01);
      step(1'b0, 1'b1, 2'b01);
      chk("R7 glitch cap_a", cap_a, exp_a);
      chk("R7 glitch irq", irq_seen, 0);

      // R8: no tick, nothing moves; then counter resumes where it stopped
      irq_seen = 0;
      repeat (5) step(1'b1, 1'b0, 2'b01);
      chk("R8 idle cap_a", cap_a, exp_a);
      chk("R8 idle irq", irq_seen, 0);
      s = n;
      step(1'b1, 1'b1, 2'b01);
      step(1'b1, 1'b1, 2'b01);
      exp_a = s + 1'b1;
      chk("R8 R2 count held over idle", cap_a, exp_a);

      // R10: reset with pin already high in both-edge mode
      do_reset(1'b1, 2'b11);
      chk("R1 cap_a after reset", cap_a, 0);
      chk("R1 cap_b after reset", cap_b, 0);
      irq_seen = 0;
      repeat (3) step(1'b1, 1'b1, 2'b11);
      chk("R10 no spurious irq", irq_seen, 0);
      chk("R10 no spurious capture", cap_a, 0);

      // R9: wrap, sticky flag, clear, and set beating clear
      do_reset(1'b0, 2'b01);
      repeat (65535) step(1'b0, 1'b1, 2'b01);
      chk("R9 no ovf before wrap", ovf, 0);
      step(1'b0, 1'b1, 2'b01);
      chk("R9 ovf at wrap", ovf, 1);
      step(1'b1, 1'b1, 2'b01);
      step(1'b1, 1'b1, 2'b01);
      chk("R9 counter wrapped to 0", cap_a, 1);
      chk("R9 ovf sticky", ovf, 1);
      @(negedge clk); tick = 1'b0; ovf_clr = 1'b1;
      @(posedge clk); #1;
      chk("R9 ovf cleared", ovf, 0);
      @(negedge clk); ovf_clr = 1'b0;
      while (n != '1) step(1'b1, 1'b1, 2'b01);
      @(negedge clk); tick = 1'b1; ovf_clr = 1'b1;
      @(posedge clk); #1; n++;
      chk("R9 wrap wins over clear", ovf, 1);
      @(negedge clk); ovf_clr = 1'b0; tick = 1'b0;

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule